// File: doc/BRIEF.md
# Holdoff-Gated Delayed Trigger Logic

This block turns two streams of comparator events into one final trigger-recognized pulse. Events on the primary channel (A) are taken only while the block is armed and no holdoff interval is running. Once an A event is accepted, the final pulse is issued at once, after a programmed number of clock cycles, or after a programmed number of secondary-channel (B) events. Which of the three applies is set by a mode register. After the pulse the block disarms itself and waits until software arms it again.

Configuration goes through a small write-only port. Three address bits pick one of eight register slots. A write happens only when three active-low enables are all low together. The controller has four states. IDLE is the disarmed state. A write of the arm bit moves IDLE to ARMED. In ARMED, an accepted A event does one of three things: it moves to DLY_TIME, it moves to DLY_EVT, or it fires at once and returns to IDLE. DLY_TIME fires and returns to IDLE when its cycle count runs out. DLY_EVT fires and returns to IDLE when its B-event count runs out. No other transitions exist.

Top module: `trig_delay_gate`

## Requirements
- R1: After reset, trig_out is 0, the block is disarmed, the mode is no-delay, and the delay and holdoff registers hold 0. An A event seen before the first arm write produces no pulse.
- R2: A register write takes effect only on a clock edge where all three bits of cfg_en_n are 0. With any enable bit high, the write has no effect.
- R3: The register slots are as follows. Slot 0 is the mode in bits 1:0 (00 no delay, 01 delay by cycles, 10 delay by B events). Slot 1 is the delay count low byte and slot 2 is its high byte. Slot 3 is the holdoff length in clocks. Writing slot 4 with bit 0 set arms the block. Slots 5, 6 and 7 ignore writes.
- R4: Both trigger inputs are sensed on rising edges. An input held high counts as a single event.
- R5: In no-delay mode, the clock edge that samples an accepted A rise makes trig_out high for the following cycle.
- R6: In cycle-delay mode with delay D>0, trig_out goes high D cycles later than it would in no-delay mode.
- R7: In event-delay mode with delay D>0, trig_out goes high in the cycle after the edge that samples the D-th B rise following acceptance. A B rise sampled on the same edge as the A acceptance is not counted.
- R8: A delay of 0 in either delay mode gives the no-delay timing. Mode value 11 also behaves as no delay.
- R9: Each accepted A event starts a holdoff of H clocks (H from slot 3). A rises sampled on the next H edges are not accepted, even when the block is armed. The first rise after that is accepted.
- R10: trig_out is a one-cycle pulse. After it, the block is disarmed and ignores all events until an arm write. An A rise sampled on the same edge as the arm write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_trig | input | 1 | Primary comparator event level |
| b_trig | input | 1 | Secondary comparator event level |
| cfg_en_n | input | 3 | Active-low write enables, all must be low |
| cfg_addr | input | 3 | Register slot select |
| cfg_wdata | input | 8 | Write data |
| trig_out | output | 1 | Final trigger pulse, one cycle |

## Verification
Two functions can fall on the same clock edge in this block. The first pair is acceptance of an A event and counting of a B event. The bench raises A and B on the same cycle in event-delay mode, then expects the pulse only after D further B rises, which shows that the coinciding B rise was not counted. The second pair is the arm write and an A rise. The bench issues the arm write while A rises and expects no pulse. It then expects the next clean A rise to fire. The holdoff boundary is checked in the same way. One rise is placed on the last blocked edge and must be ignored. Another is placed on the first free edge and must fire on the predicted cycle.

// File: rtl/trig_delay_pkg.sv
package trig_delay_pkg;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'b00,
        MODE_TIME   = 2'b01,
        MODE_EVENTS = 2'b10,
        MODE_SPARE  = 2'b11
    } dmode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_DLY_TIME = 2'd2,
        ST_DLY_EVT  = 2'd3
    } tstate_e;

    localparam int SLOT_MODE   = 0;
    localparam int SLOT_DLY_LO = 1;
    localparam int SLOT_HOLD   = 3;
    localparam int SLOT_CTRL   = 4;
    localparam int CTRL_ARM    = 0;

endpackage

// File: rtl/tdg_edge.sv
module tdg_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= din;
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/tdg_cfg_regs.sv
module tdg_cfg_regs
    import trig_delay_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int EN_W   = 3,
    parameter int DLY_W  = 16,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EN_W-1:0]   en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output dmode_e            mode,
    output logic [DLY_W-1:0]  dly,
    output logic [HOLD_W-1:0] hold_len,
    output logic              arm_req
);
    localparam int DLY_BYTES = DLY_W / DATA_W;

    logic wr_ok;
    assign wr_ok = (en_n == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_NONE;
            hold_len <= '0;
        end else if (wr_ok) begin
            if (addr == ADDR_W'(SLOT_MODE)) mode     <= dmode_e'(wdata[1:0]);
            if (addr == ADDR_W'(SLOT_HOLD)) hold_len <= wdata[HOLD_W-1:0];
        end
    end

    for (genvar g = 0; g < DLY_BYTES; g++) begin : g_dly_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                dly[g*DATA_W +: DATA_W] <= '0;
            else if (wr_ok && addr == ADDR_W'(SLOT_DLY_LO + g))
                dly[g*DATA_W +: DATA_W] <= wdata;
        end
    end

    assign arm_req = wr_ok && (addr == ADDR_W'(SLOT_CTRL)) && wdata[CTRL_ARM];
endmodule

// File: rtl/tdg_holdoff.sv
module tdg_holdoff #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HOLD_W-1:0] len,
    output logic              busy
);
    logic [HOLD_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (start)          left_q <= len;
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/trig_delay_gate.sv
module trig_delay_gate
    import trig_delay_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int EN_W   = 3,
    parameter int DLY_W  = 16,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_trig,
    input  logic              b_trig,
    input  logic [EN_W-1:0]   cfg_en_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              trig_out
);
    dmode_e            mode;
    logic [DLY_W-1:0]  dly;
    logic [HOLD_W-1:0] hold_len;
    logic              arm_req;
    logic [1:0]        rise;
    logic              a_rise, b_rise;
    logic              hold_busy;

    tstate_e           state, state_nx;
    logic [DLY_W-1:0]  dly_cnt;
    logic              cnt_load, cnt_dec, fire, accept;

    tdg_cfg_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_W(EN_W),
        .DLY_W(DLY_W), .HOLD_W(HOLD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .en_n(cfg_en_n), .addr(cfg_addr),
        .wdata(cfg_wdata), .mode(mode), .dly(dly), .hold_len(hold_len),
        .arm_req(arm_req)
    );

    tdg_edge #(.W(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .din({b_trig, a_trig}), .rise(rise)
    );
    assign a_rise = rise[0];
    assign b_rise = rise[1];

    tdg_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .start(accept), .len(hold_len), .busy(hold_busy)
    );

    assign accept = (state == ST_ARMED) && a_rise && !hold_busy;

    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        fire     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (arm_req) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (accept) begin
                    if (mode == MODE_TIME && dly != '0) begin
                        state_nx = ST_DLY_TIME;
                        cnt_load = 1'b1;
                    end else if (mode == MODE_EVENTS && dly != '0) begin
                        state_nx = ST_DLY_EVT;
                        cnt_load = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                        fire     = 1'b1;
                    end
                end
            end
            ST_DLY_TIME: begin
                if (dly_cnt == DLY_W'(1)) begin
                    state_nx = ST_IDLE;
                    fire     = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_DLY_EVT: begin
                if (b_rise) begin
                    if (dly_cnt == DLY_W'(1)) begin
                        state_nx = ST_IDLE;
                        fire     = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        dly_cnt <= '0;
        else if (cnt_load) dly_cnt <= dly;
        else if (cnt_dec)  dly_cnt <= dly_cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig_out <= 1'b0;
        else        trig_out <= fire;
    end
endmodule

// File: rtl/tdg_checker.sv
module tdg_checker
    import trig_delay_pkg::*;
#(
    parameter int EN_W   = 3,
    parameter int DLY_W  = 16,
    parameter int HOLD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [EN_W-1:0]   cfg_en_n,
    input logic              trig_out,
    input tstate_e           state,
    input logic              hold_busy,
    input dmode_e            mode,
    input logic [DLY_W-1:0]  dly,
    input logic [HOLD_W-1:0] hold_len,
    input logic [DLY_W-1:0]  dly_cnt
);
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !trig_out);

    assert_gated_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_n != '0) |=> ($stable(mode) && $stable(dly) && $stable(hold_len)));

    assert_holdoff_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && hold_busy) |=> (state == ST_ARMED));

    assert_time_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DLY_TIME && dly_cnt != DLY_W'(1))
        |=> (state == ST_DLY_TIME && ($past(dly_cnt) - dly_cnt) == DLY_W'(1)));

    assert_evt_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DLY_EVT) |-> (dly_cnt != '0));
endmodule

bind trig_delay_gate tdg_checker #(
    .EN_W(EN_W), .DLY_W(DLY_W), .HOLD_W(HOLD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en_n(cfg_en_n), .trig_out(trig_out),
    .state(state), .hold_busy(hold_busy), .mode(mode), .dly(dly),
    .hold_len(hold_len), .dly_cnt(dly_cnt)
);

// File: tb/trig_delay_gate_bench.sv
`timescale 1ns/1ps
module trig_delay_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       a_trig, b_trig;
    logic [2:0] cfg_en_n, cfg_addr;
    logic [7:0] cfg_wdata;
    logic       trig_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int    cyc;
        string req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    trig_delay_gate u_trig_delay_gate (
        .clk(clk), .rst_n(rst_n), .a_trig(a_trig), .b_trig(b_trig),
        .cfg_en_n(cfg_en_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .trig_out(trig_out)
    );

    // monitor: every pulse must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && trig_out) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL unexpected pulse (R10): actual cycle %0d, expected none", cyc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.cyc != cyc) begin
                    fails++;
                    $display("FAIL %s: pulse at cycle %0d, expected %0d", e.req, cyc, e.cyc);
                end
            end
        end
    end

    task automatic push_exp(input int c, input string r);
        exp_t e;
        e.cyc = c;
        e.req = r;
        sb.push_back(e);
    endtask

    task automatic drained(input int wait_n, input string r);
        repeat (wait_n) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d pulse(s) missing, expected at cycle %0d", r, sb.size(), sb[0].cyc);
            sb.delete();
        end
    endtask

    task automatic wr(input logic [2:0] ad, input logic [7:0] d, input logic [2:0] en);
        cfg_en_n  = en;
        cfg_addr  = ad;
        cfg_wdata = d;
        @(negedge clk);
        cfg_en_n  = 3'b111;
    endtask

    task automatic pulse_a(input int width);
        a_trig = 1'b1;
        repeat (width) @(negedge clk);
        a_trig = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_b(input int width);
        b_trig = 1'b1;
        repeat (width) @(negedge clk);
        b_trig = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic set_delay(input logic [1:0] m, input int d);
        wr(3'd0, {6'd0, m}, 3'b000);
        wr(3'd1, d[7:0], 3'b000);
        wr(3'd2, d[15:8], 3'b000);
    endtask

    task automatic arm();
        wr(3'd4, 8'h01, 3'b000);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 1'b0; a_trig = 1'b0; b_trig = 1'b0;
        cfg_en_n = 3'b111; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, disarmed
        checks++;
        if (trig_out !== 1'b0) begin
            fails++;
            $display("FAIL R1: trig_out %b, expected 0", trig_out);
        end
        pulse_a(1);
        drained(6, "R1");

        // R5: no-delay mode
        arm();
        push_exp(cyc + 1, "R5");
        pulse_a(1);
        drained(4, "R5");

        // R10: disarmed after pulse, B and A ignored
        pulse_a(1);
        pulse_b(1);
        drained(5, "R10");

        // R10: arm write on same edge as A rise ignored, then next rise fires
        a_trig = 1'b1;
        arm();
        a_trig = 1'b0;
        @(negedge clk);
        drained(3, "R10");
        push_exp(cyc + 1, "R10");
        pulse_a(1);
        drained(3, "R10");

        // R2: partial enables do not arm
        wr(3'd4, 8'h01, 3'b001);
        wr(3'd4, 8'h01, 3'b010);
        wr(3'd4, 8'h01, 3'b100);
        wr(3'd4, 8'h01, 3'b011);
        pulse_a(1);
        drained(4, "R2");

        // R3: reserved slots ignore writes
        wr(3'd5, 8'hFF, 3'b000);
        wr(3'd6, 8'hFF, 3'b000);
        wr(3'd7, 8'hFF, 3'b000);
        pulse_a(1);
        drained(4, "R3");

        // R2: partial-enable mode write ignored, so still no-delay
        wr(3'd0, 8'h01, 3'b110);
        wr(3'd1, 8'h09, 3'b101);
        arm();
        push_exp(cyc + 1, "R2");
        pulse_a(1);
        drained(4, "R2");

        // R6: cycle delay 5
        set_delay(2'b01, 5);
        arm();
        push_exp(cyc + 1 + 5, "R6");
        pulse_a(1);
        drained(10, "R6");

        // R6: cycle delay using high byte (259)
        set_delay(2'b01, 259);
        arm();
        push_exp(cyc + 1 + 259, "R6");
        pulse_a(1);
        pulse_b(1);
        drained(270, "R6");

        // R8: zero delay in cycle mode
        set_delay(2'b01, 0);
        arm();
        push_exp(cyc + 1, "R8");
        pulse_a(1);
        drained(4, "R8");

        // R8: zero delay in event mode
        set_delay(2'b10, 0);
        arm();
        push_exp(cyc + 1, "R8");
        pulse_a(1);
        drained(4, "R8");

        // R8: mode 11 acts as no delay
        set_delay(2'b11, 7);
        arm();
        push_exp(cyc + 1, "R8");
        pulse_a(1);
        drained(4, "R8");

        // R7 / R4: event delay 3, coinciding B not counted, held B counts once
        set_delay(2'b10, 3);
        arm();
        a_trig = 1'b1;
        b_trig = 1'b1;
        @(negedge clk);
        a_trig = 1'b0;
        b_trig = 1'b0;
        @(negedge clk);
        pulse_b(1);
        pulse_b(4);
        drained(3, "R7");
        push_exp(cyc + 1, "R7");
        pulse_b(1);
        drained(4, "R7");

        // R4: A held high triggers once; re-arm while high gives no new event
        set_delay(2'b00, 0);
        arm();
        push_exp(cyc + 1, "R4");
        a_trig = 1'b1;
        repeat (3) @(negedge clk);
        arm();
        repeat (3) @(negedge clk);
        drained(2, "R4");
        a_trig = 1'b0;
        @(negedge clk);
        push_exp(cyc + 1, "R4");
        pulse_a(1);
        drained(3, "R4");

        // R9: holdoff 10, rise on last blocked edge ignored
        wr(3'd3, 8'd10, 3'b000);
        arm();
        n = cyc;
        push_exp(n + 1, "R9");
        pulse_a(1);
        arm();
        wait_to(n + 10);
        pulse_a(1);
        drained(15, "R9");
        // still armed; first free rise accepted
        n = cyc;
        push_exp(n + 1, "R9");
        pulse_a(1);
        arm();
        wait_to(n + 11);
        push_exp(n + 12, "R9");
        pulse_a(1);
        drained(15, "R9");

        finish_run();
    end
endmodule